// File: doc/BRIEF.md
# Three-Lane Priority Message Arbiter with Shared Buffer Pool

This block sits in front of one outgoing link or input queue and decides which coherence message goes next. Three senders each offer messages on their own valid/ready stream. Each stream belongs to a fixed traffic class, or lane: I/O traffic, low-priority home-bound requests, and high-priority forwarded requests and replies. Accepted messages are stored in a single pool of slots that all lanes share. Each lane keeps its own arrival-order list of the slots it holds. The output stream carries the message and the tag of its lane.

The block never refuses a message with a negative acknowledgement. A sender that cannot be accepted sees `ready` low and holds its message. Forward progress comes from two rules. First, every lane can always place at least one message, because one slot per lane is held back from the shared portion of the pool. Second, lanes are served in a fixed strict order set by a parameter, and a starvation counter promotes any lane that has waited too long. While the output is stalled, the offered message is held steady until it is taken.

Top module: `vlane_arb`

## Requirements
- R1: After reset every slot is free, all three `in_ready` bits are 1 and `out_valid` is 0.
- R2: Within one lane, messages leave in the order they were accepted, with their data unchanged.
- R3: If no lane is starving and the output is not holding a stalled offer, the granted lane is the first lane in the order `PRIO_ORDER` that holds a message. `PRIO_ORDER` bits [1:0] name the top lane, [3:2] the next and [5:4] the last. The default order is high, then low, then I/O, so high beats low.
- R4: A lane that holds no message always has `in_ready` = 1, whatever the other lanes occupy.
- R5: A lane holding at least one message may take a shared slot. It is ready only when the free shared slots, POOL-3 minus the sum over lanes of (occupancy-1) for each non-empty lane, exceed the number of non-empty lanes with a lower index. Total occupancy never exceeds POOL.
- R6: Every accepted message is delivered exactly once. When inputs stop and `out_ready` stays high, all lanes drain and `out_valid` falls to 0.
- R7: A lane that holds a message has a wait counter. The counter rises each cycle the lane is not served, saturates at `STARVE_LIM`, and clears when the lane is served or is empty. A lane whose counter has reached `STARVE_LIM` is granted ahead of non-starving lanes. Ties among starving lanes follow `PRIO_ORDER`.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` = 1 with the same `out_lane` and `out_data`.
- R9: A message accepted at a clock edge can appear on the output from the following cycle onward. `out_lane` encodes I/O as 0, low as 1 and high as 2. Input lane i uses `in_valid[i]`, `in_ready[i]` and `in_data[i*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 3 | Per-lane message offered (bit = lane code) |
| in_ready | output | 3 | Per-lane acceptance |
| in_data | input | 3*DW | Per-lane message payloads, lane i at bits i*DW upward |
| out_valid | output | 1 | A message is offered on the output |
| out_ready | input | 1 | Downstream takes the offered message |
| out_lane | output | 2 | Lane tag of the offered message |
| out_data | output | DW | Offered payload |

## Verification
The hardest state to reach is a pool that is nearly full while one lane sits in the low-priority tail. In that state the reserve, the shared-slot ranking and the starvation promotion all act in the same cycles. The directed phases reach it by holding `out_ready` low while only the low lane streams until its `ready` drops. They then keep the high lane saturated with the output open, so the low lane must win through its wait counter. Long random runs with skewed valid and ready densities repeat these collisions. A cycle-accurate bench model compares every output on every cycle.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
  localparam int NL = 3;
  typedef logic [1:0] lane_t;
  localparam lane_t LANE_IO = 2'd0;
  localparam lane_t LANE_LO = 2'd1;
  localparam lane_t LANE_HI = 2'd2;
endpackage

// File: rtl/vlane_idx_fifo.sv
module vlane_idx_fifo #(
  parameter int DEPTH = 8,
  parameter int IW    = 3,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic          pop,
  output logic [IW-1:0] head_idx,
  output logic [CW-1:0] count
);
  logic [IW-1:0] slots [DEPTH];
  logic [PW-1:0] wr_q, rd_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign head_idx = slots[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        slots[wr_q] <= push_idx;
        wr_q        <= bump(wr_q);
      end
      if (pop) rd_q <= bump(rd_q);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/vlane_slot_pool.sv
module vlane_slot_pool #(
  parameter int POOL = 8,
  parameter int NL   = 3,
  localparam int SW  = $clog2(POOL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NL-1:0]  take,
  output logic [SW-1:0]  take_idx [NL],
  input  logic           give_back,
  input  logic [SW-1:0]  give_idx
);
  logic [POOL-1:0] free_q, taken;

  always_comb begin
    logic [POOL-1:0] avail;
    avail = free_q;
    taken = '0;
    for (int l = 0; l < NL; l++) begin
      logic found;
      found       = 1'b0;
      take_idx[l] = '0;
      for (int s = 0; s < POOL; s++) begin
        if (avail[s] && !found) begin
          take_idx[l] = SW'(s);
          found       = 1'b1;
        end
      end
      if (take[l] && found) begin
        avail[take_idx[l]] = 1'b0;
        taken[take_idx[l]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else begin
      logic [POOL-1:0] nxt;
      nxt = free_q & ~taken;
      if (give_back) nxt[give_idx] = 1'b1;
      free_q <= nxt;
    end
  end
endmodule

// File: rtl/vlane_pick.sv
module vlane_pick
  import vlane_pkg::*;
#(
  parameter int          STARVE_LIM = 32,
  parameter logic [5:0]  PRIO_ORDER = {LANE_IO, LANE_LO, LANE_HI},
  localparam int         WW         = $clog2(STARVE_LIM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] nonempty,
  input  logic          out_ready,
  output lane_t         gnt,
  output logic          gnt_valid,
  output logic          starve_any,
  output logic          locked
);
  logic [WW-1:0] wait_q [NL];
  logic [NL-1:0] starving;
  lane_t         lock_lane;

  // first lane in priority order whose bit is set in mask; {found, lane}
  function automatic logic [2:0] first_in_order(input logic [NL-1:0] mask);
    for (int k = 0; k < NL; k++) begin
      if (mask[PRIO_ORDER[2*k +: 2]]) return {1'b1, PRIO_ORDER[2*k +: 2]};
    end
    return 3'b000;
  endfunction

  always_comb begin
    logic [2:0] hit_s, hit_n;
    for (int l = 0; l < NL; l++)
      starving[l] = nonempty[l] && (int'(wait_q[l]) >= STARVE_LIM);
    starve_any = |starving;
    hit_s      = first_in_order(starving);
    hit_n      = first_in_order(nonempty);
    gnt_valid  = |nonempty;
    if (locked)      gnt = lock_lane;
    else if (hit_s[2]) gnt = hit_s[1:0];
    else             gnt = hit_n[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      lock_lane <= LANE_IO;
      for (int l = 0; l < NL; l++) wait_q[l] <= '0;
    end else begin
      locked    <= gnt_valid && !out_ready;
      lock_lane <= gnt;
      for (int l = 0; l < NL; l++) begin
        if (nonempty[l] && !(gnt_valid && out_ready && gnt == lane_t'(l)))
          wait_q[l] <= (int'(wait_q[l]) >= STARVE_LIM) ? wait_q[l] : wait_q[l] + 1'b1;
        else
          wait_q[l] <= '0;
      end
    end
  end
endmodule

// File: rtl/vlane_arb.sv
module vlane_arb
  import vlane_pkg::*;
#(
  parameter int         DW         = 16,
  parameter int         POOL       = 8,
  parameter int         STARVE_LIM = 32,
  parameter logic [5:0] PRIO_ORDER = {LANE_IO, LANE_LO, LANE_HI}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       in_valid,
  output logic [2:0]       in_ready,
  input  logic [3*DW-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_lane,
  output logic [DW-1:0]    out_data
);
  localparam int SW     = $clog2(POOL);
  localparam int CW     = $clog2(POOL + 1);
  localparam int SHARED = POOL - NL;

  logic [DW-1:0] store [POOL];
  logic [CW-1:0] lane_used [NL];
  logic [SW-1:0] lane_head [NL];
  logic [SW-1:0] alloc_idx [NL];
  logic [NL-1:0] push_fire, pop_lane, lane_busy;
  logic          pop_fire, starve_any, grant_locked;
  lane_t         gnt;
  logic [CW-1:0] occ_total;

  // shared slots left after each non-empty lane keeps its reserved one
  function automatic int shared_left(input int used0, input int used1, input int used2);
    int taken;
    taken = (used0 > 0 ? used0 - 1 : 0) + (used1 > 0 ? used1 - 1 : 0) + (used2 > 0 ? used2 - 1 : 0);
    return SHARED - taken;
  endfunction

  always_comb begin
    int left, ahead, sum;
    left  = shared_left(int'(lane_used[0]), int'(lane_used[1]), int'(lane_used[2]));
    ahead = 0;
    sum   = 0;
    for (int l = 0; l < NL; l++) begin
      lane_busy[l] = lane_used[l] != '0;
      in_ready[l]  = !lane_busy[l] || (left > ahead);
      if (lane_busy[l]) ahead++;
      sum += int'(lane_used[l]);
    end
    occ_total = CW'(sum);
  end

  assign push_fire = in_valid & in_ready;
  assign pop_fire  = out_valid && out_ready;

  generate
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign pop_lane[l] = pop_fire && (gnt == lane_t'(l));
      vlane_idx_fifo #(.DEPTH(POOL), .IW(SW)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_fire[l]),
        .push_idx (alloc_idx[l]),
        .pop      (pop_lane[l]),
        .head_idx (lane_head[l]),
        .count    (lane_used[l])
      );
    end
  endgenerate

  vlane_slot_pool #(.POOL(POOL), .NL(NL)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (push_fire),
    .take_idx  (alloc_idx),
    .give_back (pop_fire),
    .give_idx  (lane_head[gnt])
  );

  vlane_pick #(.STARVE_LIM(STARVE_LIM), .PRIO_ORDER(PRIO_ORDER)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .nonempty   (lane_busy),
    .out_ready  (out_ready),
    .gnt        (gnt),
    .gnt_valid  (out_valid),
    .starve_any (starve_any),
    .locked     (grant_locked)
  );

  always_ff @(posedge clk) begin
    for (int l = 0; l < NL; l++)
      if (push_fire[l]) store[alloc_idx[l]] <= in_data[l*DW +: DW];
  end

  assign out_lane = gnt;
  assign out_data = store[lane_head[gnt]];
endmodule

// File: rtl/vlane_arb_chk.sv
module vlane_arb_chk #(
  parameter int DW   = 16,
  parameter int POOL = 8,
  localparam int CW  = $clog2(POOL + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    in_ready,
  input logic [2:0]    push_fire,
  input logic [2:0]    pop_lane,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    out_lane,
  input logic [DW-1:0] out_data,
  input logic [2:0]    lane_busy,
  input logic          starve_any,
  input logic          grant_locked,
  input logic [CW-1:0] occ_total
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_lane) && $stable(out_data)); // R8
  AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_total) <= POOL); // R5
  AST_EMPTY_LANE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_busy[2] |-> in_ready[2]); // R4
  AST_HI_BEATS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && lane_busy[2] && !starve_any && !grant_locked |-> out_lane == 2'd2); // R3
  AST_NO_EMPTY_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lane_busy[out_lane]); // R6
  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_lane)); // R6
  AST_NO_SAME_CYCLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire[1] && !lane_busy[1] |-> !(out_valid && out_lane == 2'd1)); // R9
endmodule

bind vlane_arb vlane_arb_chk #(.DW(DW), .POOL(POOL)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .push_fire    (push_fire),
  .pop_lane     (pop_lane),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_lane     (out_lane),
  .out_data     (out_data),
  .lane_busy    (lane_busy),
  .starve_any   (starve_any),
  .grant_locked (grant_locked),
  .occ_total    (occ_total)
);

// File: tb/tb_vlane_arb.sv
module tb_vlane_arb;
  localparam int DW = 8, POOL = 8, LIM = 6, SHARED = POOL - 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] in_valid = '0, in_ready;
  logic [3*DW-1:0] in_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [1:0] out_lane;
  logic [DW-1:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] mq [3][$];
  int wc [3];
  bit mlock = 0;
  int mlock_lane = 0;

  always #4 clk = ~clk;

  vlane_arb #(.DW(DW), .POOL(POOL), .STARVE_LIM(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_lane(out_lane), .out_data(out_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_ready(input int l);
    int left = SHARED, ahead = 0;
    for (int k = 0; k < 3; k++) if (mq[k].size() > 0) left -= mq[k].size() - 1;
    for (int k = 0; k < l; k++) if (mq[k].size() > 0) ahead++;
    return (mq[l].size() == 0) || (left > ahead);
  endfunction

  // service order high, low, I/O; starving lanes first
  function automatic int exp_pick();
    int order [3] = '{2, 1, 0};
    if (mlock) return mlock_lane;
    foreach (order[k]) if (mq[order[k]].size() > 0 && wc[order[k]] >= LIM) return order[k];
    foreach (order[k]) if (mq[order[k]].size() > 0) return order[k];
    return 0;
  endfunction

  // compare at negedge, drive, then advance model across the posedge
  task automatic step(input logic [2:0] v, input logic rdy);
    bit ev;
    int el;
    bit acc [3];
    ev = (mq[0].size() + mq[1].size() + mq[2].size()) > 0;
    el = exp_pick();
    for (int l = 0; l < 3; l++)
      chk(in_ready[l] == exp_ready(l), (mq[l].size() == 0) ? "R4" : "R5", in_ready[l], exp_ready(l));
    chk(out_valid == ev, "R9", out_valid, ev);
    if (ev && out_valid) begin
      chk(out_lane == 2'(el), mlock ? "R8" : ((wc[el] >= LIM) ? "R7" : "R3"), out_lane, el);
      if (out_lane == 2'(el)) chk(out_data == mq[el][0], "R2", out_data, mq[el][0]);
    end
    in_valid  = v;
    out_ready = rdy;
    for (int l = 0; l < 3; l++) in_data[l*DW +: DW] = DW'($urandom);
    for (int l = 0; l < 3; l++) acc[l] = v[l] && exp_ready(l);
    @(posedge clk);
    for (int l = 0; l < 3; l++) begin
      if (mq[l].size() > 0 && !(ev && rdy && el == l)) wc[l] = (wc[l] >= LIM) ? LIM : wc[l] + 1;
      else wc[l] = 0;
    end
    mlock = ev && !rdy;
    mlock_lane = el;
    if (ev && rdy) void'(mq[el].pop_front());
    for (int l = 0; l < 3; l++) if (acc[l]) mq[l].push_back(in_data[l*DW +: DW]);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    for (int l = 0; l < 3; l++) wc[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 3'b111, "R1", in_ready, 7);
    chk(out_valid == 1'b0, "R1", out_valid, 0);

    // fill the low lane with the output stalled until its ready drops
    for (int i = 0; i < 10; i++) step(3'b010, 1'b0);
    chk(in_ready[1] == 1'b0, "R5", in_ready[1], 0);
    chk(in_ready[2] == 1'b1 && in_ready[0] == 1'b1, "R4", in_ready, 5);
    // high and I/O still get in while low is full
    step(3'b101, 1'b0);
    step(3'b000, 1'b0);

    // high lane saturated, low lane must be promoted by its wait counter
    for (int i = 0; i < 40; i++) step(3'b110, 1'b1);

    // random mixes with different densities
    for (int phase = 0; phase < 4; phase++) begin
      for (int i = 0; i < 800; i++) begin
        logic [2:0] v;
        logic r;
        for (int l = 0; l < 3; l++) v[l] = ($urandom % 4) < (phase + 1);
        r = ($urandom % 4) < (4 - phase + (phase == 3 ? 1 : 0));
        step(v, r);
      end
    end

    // drain
    for (int i = 0; i < 40; i++) step(3'b000, 1'b1);
    chk(out_valid == 1'b0, "R6", out_valid, 0);
    chk((mq[0].size() + mq[1].size() + mq[2].size()) == 0, "R6",
        mq[0].size() + mq[1].size() + mq[2].size(), 0);
    chk(in_ready == 3'b111, "R4", in_ready, 7);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule